// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block sits behind a slow-rate infrared receive UART and turns its stream of decoded bytes into bare packet data. Each byte that arrives is checked against three fixed control values. The start flag (0xC0) opens a frame. The stop flag (0xC1) closes it. The escape byte (0x7D) marks the next byte as one that was transformed. Only the restored payload, with its trailing 16-bit checksum still attached, goes out on a one-byte-per-pulse write port toward a receive FIFO. The block does not check the checksum.

A 12-bit live byte counter follows the frame as it is filled. A programmable 12-bit limit caps how long a frame may be. When a frame ends, a one-cycle completion pulse carries a status byte and the final length. The frame can end on the stop flag, on a start flag that arrives too early, or on an overlong frame. A polarity input inverts every incoming byte for a receiver whose line sense is flipped. A constant 16-bit word gives the two flag values to whoever needs to read them.

Top module: `sir_rx_unwrap`

## Requirements
- R1: `flag_word` always reads 16'hC1C0, with the start flag 0xC0 in bits [7:0] and the stop flag 0xC1 in bits [15:8].
- R2: Bytes received while no frame is open, other than 0xC0, produce no write and no completion pulse, and they leave `byte_count` unchanged.
- R3: A 0xC0 received while no frame is open opens a frame and clears `byte_count` to 0. Further 0xC0 bytes received before any payload are discarded with no effect.
- R4: Inside a frame, the byte 0x7D is never written. The byte that follows it is written XORed with 0x20.
- R5: Each payload byte is written with a one-cycle `fifo_we` pulse, one clock after it is accepted. In the same cycle, `byte_count` rises by one.
- R6: A 0xC1 received in a frame that holds at least one payload byte gives a one-cycle `frame_done` with `frame_status` 8'h00 and `frame_len` equal to the payload count, and the frame closes. A 0xC1 received in a frame with no payload closes the frame with no pulse.
- R7: A 0xC0 received in a frame that holds payload gives `frame_done` with `frame_status` 8'h04 (missing stop flag) and the old count in `frame_len`. In the same cycle it starts a new frame, with `byte_count` 0.
- R8: A payload byte that arrives when the count already equals `max_len` (nonzero) is not written. It gives `frame_done` with `frame_status` 8'h10 and `frame_len` = `max_len`, the frame closes, and later bytes are dropped as in R2.
- R9: When `rx_invert` is 1, each received byte is bit-inverted before any of the above decoding.
- R10: After reset, `fifo_we`, `frame_done` and `byte_count` are 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte from the UART |
| rx_invert | input | 1 | Invert each received byte when 1 |
| max_len | input | 12 | Largest payload count allowed in a frame |
| fifo_we | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | 8 | Restored payload byte |
| byte_count | output | 12 | Live count of bytes written in the current frame |
| frame_done | output | 1 | One-cycle frame completion pulse |
| frame_status | output | 8 | Completion status: 00 good, 04 missing stop flag, 10 too long |
| frame_len | output | 12 | Payload count of the completed frame |
| flag_word | output | 16 | Constant start and stop flag values |

## Verification
Two events can land in the same cycle: a frame closing with the missing-stop-flag status, and the next frame opening, because one early 0xC0 does both. The bench provokes this by sending a start flag directly after payload. In the cycle after that byte, it checks that `frame_done` carries status 04 and the old length in `frame_len`, and that `byte_count` has already dropped to 0. A following payload byte must then count from 1, which confirms that the new frame really opened.

// File: rtl/sir_rx_unwrap.sv
module sir_rx_unwrap #(
  parameter int        LEN_W    = 12,
  parameter logic [7:0] FLAG_BOF = 8'hC0,
  parameter logic [7:0] FLAG_EOF = 8'hC1,
  parameter logic [7:0] ESC_CHR  = 8'h7D,
  parameter logic [7:0] ESC_XOR  = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_invert,
  input  logic [LEN_W-1:0] max_len,
  output logic             fifo_we,
  output logic [7:0]       fifo_data,
  output logic [LEN_W-1:0] byte_count,
  output logic             frame_done,
  output logic [7:0]       frame_status,
  output logic [LEN_W-1:0] frame_len,
  output logic [15:0]      flag_word
);
  localparam logic [7:0] ST_OK   = 8'h00;
  localparam logic [7:0] ST_NOEOF = 8'h04;
  localparam logic [7:0] ST_LONG = 8'h10;

  logic       in_frame, esc_pend;
  logic [7:0] d;

  assign d         = rx_invert ? ~rx_byte : rx_byte;
  assign flag_word = {FLAG_EOF, FLAG_BOF};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame     <= 1'b0;
      esc_pend     <= 1'b0;
      byte_count   <= '0;
      fifo_we      <= 1'b0;
      fifo_data    <= '0;
      frame_done   <= 1'b0;
      frame_status <= ST_OK;
      frame_len    <= '0;
    end else begin
      fifo_we    <= 1'b0;
      frame_done <= 1'b0;
      if (rx_valid) begin
        if (!in_frame) begin
          if (d == FLAG_BOF) begin
            in_frame   <= 1'b1;
            esc_pend   <= 1'b0;
            byte_count <= '0;
          end
        end else if (d == FLAG_BOF) begin
          esc_pend <= 1'b0;
          if (byte_count != '0) begin
            frame_done   <= 1'b1;
            frame_status <= ST_NOEOF;
            frame_len    <= byte_count;
          end
          byte_count <= '0;
        end else if (d == FLAG_EOF) begin
          in_frame <= 1'b0;
          esc_pend <= 1'b0;
          if (byte_count != '0) begin
            frame_done   <= 1'b1;
            frame_status <= ST_OK;
            frame_len    <= byte_count;
          end
        end else if (d == ESC_CHR && !esc_pend) begin
          esc_pend <= 1'b1;
        end else begin
          esc_pend <= 1'b0;
          if (byte_count == max_len) begin
            in_frame <= 1'b0;
            if (byte_count != '0) begin
              frame_done   <= 1'b1;
              frame_status <= ST_LONG;
              frame_len    <= byte_count;
            end
          end else begin
            fifo_we    <= 1'b1;
            fifo_data  <= esc_pend ? (d ^ ESC_XOR) : d;
            byte_count <= byte_count + 1'b1;
          end
        end
      end
    end
  end

  a_r5_we_counts: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> byte_count == $past(byte_count) + 1'b1 || byte_count == 1);
  a_r8_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> byte_count <= $past(max_len));
  a_r6_done_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_len != '0);
  a_r2_we_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_we && frame_done));
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_status == ST_NOEOF) |-> byte_count == '0);
  a_r6_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $onehot0(frame_status));
endmodule

// File: tb/sim_sir_rx_unwrap.sv
module sim_sir_rx_unwrap;
  logic        clk = 0, rst_n = 0, rx_valid = 0, rx_invert = 0;
  logic [7:0]  rx_byte = 0;
  logic [11:0] max_len = 12'd5;
  logic        fifo_we, frame_done;
  logic [7:0]  fifo_data, frame_status;
  logic [11:0] byte_count, frame_len;
  logic [15:0] flag_word;
  int checks = 0, fails = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  sir_rx_unwrap u0 (.clk, .rst_n, .rx_valid, .rx_byte, .rx_invert, .max_len,
    .fifo_we, .fifo_data, .byte_count, .frame_done, .frame_status, .frame_len, .flag_word);

  // {inv, byte, we, data, done, status, len, count}
  localparam int N = 15;
  localparam logic [50:0] V [N] = '{
    {1'b0, 8'h55, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd0}, // R2 outside
    {1'b0, 8'hC0, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd0}, // R3 open
    {1'b0, 8'hC0, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd0}, // R3 extra BOF
    {1'b0, 8'h11, 1'b1, 8'h11, 1'b0, 8'h00, 12'd0, 12'd1}, // R5
    {1'b0, 8'h7D, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd1}, // R4 escape
    {1'b0, 8'h5D, 1'b1, 8'h7D, 1'b0, 8'h00, 12'd0, 12'd2}, // R4 restored
    {1'b0, 8'hC1, 1'b0, 8'h00, 1'b1, 8'h00, 12'd2, 12'd2}, // R6 good close
    {1'b0, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd2}, // R2 outside
    {1'b0, 8'hC0, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd0}, // R3
    {1'b0, 8'hC1, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd0}, // R6 empty
    {1'b0, 8'hC0, 1'b0, 8'h00, 1'b0, 8'h00, 12'd0, 12'd0}, // R3
    {1'b0, 8'h33, 1'b1, 8'h33, 1'b0, 8'h00, 12'd0, 12'd1}, // R5
    {1'b0, 8'hC0, 1'b0, 8'h00, 1'b1, 8'h04, 12'd1, 12'd0}, // R7 restart
    {1'b1, 8'hBB, 1'b1, 8'h44, 1'b0, 8'h00, 12'd0, 12'd1}, // R9 inverted data
    {1'b1, 8'h3E, 1'b0, 8'h00, 1'b1, 8'h00, 12'd1, 12'd1}  // R9 inverted EOF
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic inv, input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_invert = inv; rx_byte = b;
    @(posedge clk);
    #2;
    rx_valid = 0;
  endtask

  task automatic check_vec(input logic [50:0] v, input int idx);
    string r;
    r = $sformatf("R2-9 vec%0d", idx);
    chk(fifo_we == v[41], {r, " we"}, fifo_we, v[41]);
    if (v[41]) chk(fifo_data == v[40:33], {r, " data"}, fifo_data, v[40:33]);
    chk(frame_done == v[32], {r, " done"}, frame_done, v[32]);
    if (v[32]) begin
      chk(frame_status == v[31:24], {r, " status"}, frame_status, v[31:24]);
      chk(frame_len == v[23:12], {r, " len"}, frame_len, v[23:12]);
    end
    chk(byte_count == v[11:0], {r, " count"}, byte_count, v[11:0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chk(fifo_we == 0 && frame_done == 0, "R10 strobes", {fifo_we, frame_done}, 0);
    chk(byte_count == 0, "R10 count", byte_count, 0);
    chk(flag_word == 16'hC1C0, "R1 flags", flag_word, 16'hC1C0);
    @(negedge clk); rst_n = 1;
    // R10: no frame open after reset, so data is dropped
    step(0, 8'h12);
    chk(fifo_we == 0, "R10 closed after reset", fifo_we, 0);
    for (int i = 0; i < N; i++) begin
      step(V[i][50], V[i][49:42]);
      check_vec(V[i], i);
    end
    // R8 length limit
    max_len = 12'd2;
    step(0, 8'hC0);
    step(0, 8'h01);
    chk(fifo_we == 1 && byte_count == 1, "R8 first", byte_count, 1);
    step(0, 8'h02);
    chk(fifo_we == 1 && byte_count == 2, "R8 at limit", byte_count, 2);
    step(0, 8'h03);
    chk(fifo_we == 0, "R8 over not written", fifo_we, 0);
    chk(frame_done == 1 && frame_status == 8'h10, "R8 status", frame_status, 8'h10);
    chk(frame_len == 12'd2, "R8 len", frame_len, 2);
    step(0, 8'h04);
    chk(fifo_we == 0 && frame_done == 0 && byte_count == 2, "R8 then dropped", byte_count, 2);
    // R4 escaped flag value stored as data
    max_len = 12'd5;
    step(0, 8'hC0);
    step(0, 8'h7D);
    step(0, 8'hE0);
    chk(fifo_we == 1 && fifo_data == 8'hC0, "R4 escaped C0", fifo_data, 8'hC0);
    // R7 new frame counts from one
    step(0, 8'h66);
    step(0, 8'hC0);
    chk(frame_done == 1 && frame_len == 12'd2 && byte_count == 0, "R7 same cycle", byte_count, 0);
    step(0, 8'h77);
    chk(fifo_we == 1 && byte_count == 1, "R7 new frame", byte_count, 1);
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule